// File: doc/BRIEF.md
# Signed Multiply-Step Unit with Y Register

The unit performs one step of a shift-and-add signed multiply per strobe and owns the Y register, which holds the multiplier and collects the low half of the product. For a step, the caller supplies the running partial product as the first operand, the multiplicand as the second operand, and the N and V flags produced by the previous step. The unit returns a new partial product together with N, Z, V and C. In the same step, Y moves one place towards bit 0.

Software loads Y with a write command and reads it back with a read command. Both commands carry a register field that must be zero, and the unit reports an illegal command when that field is not zero. A caller that issues DATA_W steps, then one more step with a zero second operand, gets the high half of the product in the result and the low half in Y. The sequencing of those steps lies outside the block. All state is registered and becomes visible one clock after the strobe.

Top module: `mulstep_unit`

## Requirements
- R1: After reset, Y, the result, the four flags, `illegal_o` and `collide_o` are all zero.
- R2: A step computes the result as A' + G, where A' is the first operand shifted right by one bit and its top bit is replaced by `flag_n_i` XOR `flag_v_i`. The result appears one clock after the strobe.
- R3: The addend G equals the second operand when Y bit 0 is 1, and equals zero when Y bit 0 is 0.
- R4: A step sets N to the result's top bit and Z when the result is zero. It sets C to the carry out of A' + G, and V when A' and G share a sign bit that differs from the result's sign bit.
- R5: A step loads Y with the old Y shifted right by one bit, with bit 0 of the first operand entering the top bit.
- R6: A write-Y with `wr_dst_i` equal to 0 loads Y with (first operand + second operand) modulo 2^DATA_W.
- R7: A write-Y with a nonzero `wr_dst_i` leaves Y unchanged and raises `illegal_o` for one cycle.
- R8: When `rd_en_i` is high and `rd_src_i` is 0, `rd_data_o` equals Y in the same cycle. When `rd_src_i` is nonzero, `rd_data_o` is zero and `illegal_o` rises the next cycle. When `rd_en_i` is low, `rd_data_o` is zero.
- R9: A step and a write-Y in the same cycle raise `collide_o` for one cycle. The write is applied and the step is discarded, so the result and the flags keep their values.
- R10: In a cycle with no step and no write-Y, Y, the result and the flags keep their values.
- R11: Starting with the first operand, N and V at zero, run DATA_W steps, each fed the previous result and flags, then one more step with a zero second operand. The final result and Y then form the 2*DATA_W-bit product of the signed multiplicand and the unsigned value Y held at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en_i | input | 1 | Perform one multiply step |
| wry_en_i | input | 1 | Write Y with op_a_i + op_b_i |
| rd_en_i | input | 1 | Read Y on rd_data_o |
| wr_dst_i | input | 5 | Destination field of the write command; must be 0 |
| rd_src_i | input | 5 | First-source field of the read command; must be 0 |
| op_a_i | input | DATA_W | First operand (partial product) |
| op_b_i | input | DATA_W | Second operand (multiplicand or immediate) |
| flag_n_i | input | 1 | Current N flag |
| flag_v_i | input | 1 | Current V flag |
| res_o | output | DATA_W | Registered step result |
| flag_n_o | output | 1 | Negative flag of the last step |
| flag_z_o | output | 1 | Zero flag of the last step |
| flag_v_o | output | 1 | Overflow flag of the last step |
| flag_c_o | output | 1 | Carry flag of the last step |
| y_o | output | DATA_W | Current Y register |
| rd_data_o | output | DATA_W | Read-Y data, zero unless the read is legal |
| illegal_o | output | 1 | Pulse: a command with a nonzero must-be-zero field was seen |
| collide_o | output | 1 | Pulse: a step and a write-Y arrived in the same cycle |

## Verification
At a four-bit width, the bench steps through every combination of first operand, second operand, Y and N/V pair. This catches a sign bit injected from N alone instead of N XOR V, gating on the wrong bit of Y, a Y shift that takes in the result bit rather than the operand bit, and a V computed on the unshifted operand. The full product sweep multiplies every signed multiplicand by every unsigned multiplier. A design that ignores the flag feedback fails here, because it drops the sign of an overflowed partial sum and returns wrong high halves for negative multiplicands. The directed cases cover write-Y wraparound, illegal fields that must leave Y untouched, a read that must return zero on a bad field, and a simultaneous step and write that must not change the result.

// File: rtl/mulstep_pkg.sv
package mulstep_pkg;

    // width of the register-index fields carried by the commands
    localparam int unsigned FIELD_W = 5;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

endpackage

// File: rtl/mulstep_shift_gate.sv
// Builds the two adder operands of a multiply step.
module mulstep_shift_gate #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] op_a_i,
    input  logic [DATA_W-1:0] op_b_i,
    input  logic              flag_n_i,
    input  logic              flag_v_i,
    input  logic              y_lsb_i,
    output logic [DATA_W-1:0] shifted_o,
    output logic [DATA_W-1:0] gated_o
);

    localparam int unsigned TOP = DATA_W - 1;

    // the true sign of the previous sum replaces the bit shifted in
    always_comb begin
        shifted_o      = op_a_i >> 1;
        shifted_o[TOP] = flag_n_i ^ flag_v_i;
    end

    // one AND gate per bit, enabled by the multiplier bit in Y
    for (genvar i = 0; i < DATA_W; i++) begin : g_gate
        assign gated_o[i] = op_b_i[i] & y_lsb_i;
    end

endmodule

// File: rtl/mulstep_adder_cc.sv
// Shared adder and condition-code generation.
module mulstep_adder_cc
    import mulstep_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    output logic [DATA_W-1:0] sum_o,
    output cc_t               cc_o
);

    localparam int unsigned TOP = DATA_W - 1;

    logic [DATA_W:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, x_i} + {1'b0, y_i};
        sum_o    = wide_sum[TOP:0];
        cc_o.n   = wide_sum[TOP];
        cc_o.z   = (wide_sum[TOP:0] == '0);
        cc_o.c   = wide_sum[DATA_W];
        cc_o.v   = (x_i[TOP] == y_i[TOP]) && (wide_sum[TOP] != x_i[TOP]);
    end

endmodule

// File: rtl/mulstep_cmd_decode.sv
// Command legality and conflict decode.
module mulstep_cmd_decode
    import mulstep_pkg::*;
(
    input  logic               step_en_i,
    input  logic               wry_en_i,
    input  logic               rd_en_i,
    input  logic [FIELD_W-1:0] wr_dst_i,
    input  logic [FIELD_W-1:0] rd_src_i,
    output logic               do_step_o,
    output logic               do_write_o,
    output logic               read_ok_o,
    output logic               illegal_o,
    output logic               collide_o
);

    logic wr_field_bad;
    logic rd_field_bad;

    always_comb begin
        wr_field_bad = (wr_dst_i != '0);
        rd_field_bad = (rd_src_i != '0);
        // a write-Y always claims the cycle, legal or not
        do_write_o   = wry_en_i && !wr_field_bad;
        do_step_o    = step_en_i && !wry_en_i;
        read_ok_o    = rd_en_i && !rd_field_bad;
        illegal_o    = (wry_en_i && wr_field_bad) || (rd_en_i && rd_field_bad);
        collide_o    = step_en_i && wry_en_i;
    end

endmodule

// File: rtl/mulstep_unit.sv
module mulstep_unit
    import mulstep_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_en_i,
    input  logic               wry_en_i,
    input  logic               rd_en_i,
    input  logic [FIELD_W-1:0] wr_dst_i,
    input  logic [FIELD_W-1:0] rd_src_i,
    input  logic [DATA_W-1:0]  op_a_i,
    input  logic [DATA_W-1:0]  op_b_i,
    input  logic               flag_n_i,
    input  logic               flag_v_i,
    output logic [DATA_W-1:0]  res_o,
    output logic               flag_n_o,
    output logic               flag_z_o,
    output logic               flag_v_o,
    output logic               flag_c_o,
    output logic [DATA_W-1:0]  y_o,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               illegal_o,
    output logic               collide_o
);

    localparam int unsigned TOP = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] y;
        logic [DATA_W-1:0] res;
        cc_t               cc;
        logic              illegal;
        logic              collide;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] shifted, gated;
    logic [DATA_W-1:0] add_x, add_y, add_sum;
    cc_t               add_cc;
    logic              do_step, do_write, read_ok, illegal_c, collide_c;

    mulstep_cmd_decode u_dec (
        .step_en_i  (step_en_i),
        .wry_en_i   (wry_en_i),
        .rd_en_i    (rd_en_i),
        .wr_dst_i   (wr_dst_i),
        .rd_src_i   (rd_src_i),
        .do_step_o  (do_step),
        .do_write_o (do_write),
        .read_ok_o  (read_ok),
        .illegal_o  (illegal_c),
        .collide_o  (collide_c)
    );

    mulstep_shift_gate #(.DATA_W(DATA_W)) u_sg (
        .op_a_i    (op_a_i),
        .op_b_i    (op_b_i),
        .flag_n_i  (flag_n_i),
        .flag_v_i  (flag_v_i),
        .y_lsb_i   (st_q.y[0]),
        .shifted_o (shifted),
        .gated_o   (gated)
    );

    // one adder serves both the step sum and the write-Y sum
    always_comb begin
        add_x = wry_en_i ? op_a_i : shifted;
        add_y = wry_en_i ? op_b_i : gated;
    end

    mulstep_adder_cc #(.DATA_W(DATA_W)) u_add (
        .x_i   (add_x),
        .y_i   (add_y),
        .sum_o (add_sum),
        .cc_o  (add_cc)
    );

    always_comb begin
        st_d         = st_q;
        st_d.illegal = illegal_c;
        st_d.collide = collide_c;
        if (do_write) begin
            st_d.y = add_sum;
        end else if (do_step) begin
            st_d.y   = {op_a_i[0], st_q.y[TOP:1]};
            st_d.res = add_sum;
            st_d.cc  = add_cc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o     = st_q.res;
    assign flag_n_o  = st_q.cc.n;
    assign flag_z_o  = st_q.cc.z;
    assign flag_v_o  = st_q.cc.v;
    assign flag_c_o  = st_q.cc.c;
    assign y_o       = st_q.y;
    assign rd_data_o = read_ok ? st_q.y : '0;
    assign illegal_o = st_q.illegal;
    assign collide_o = st_q.collide;

endmodule

// File: rtl/mulstep_checker.sv
module mulstep_checker
    import mulstep_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               step_en_i,
    input logic               wry_en_i,
    input logic               rd_en_i,
    input logic [FIELD_W-1:0] wr_dst_i,
    input logic [FIELD_W-1:0] rd_src_i,
    input logic [DATA_W-1:0]  op_a_i,
    input logic [DATA_W-1:0]  op_b_i,
    input logic [DATA_W-1:0]  res_o,
    input logic               flag_n_o,
    input logic               flag_z_o,
    input logic [DATA_W-1:0]  y_o,
    input logic [DATA_W-1:0]  rd_data_o,
    input logic               illegal_o,
    input logic               collide_o
);

    localparam int unsigned TOP = DATA_W - 1;

    assert_y_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && !wry_en_i) |=> (y_o == {$past(op_a_i[0]), $past(y_o[TOP:1])}));

    assert_nz_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && !wry_en_i) |=> ((flag_z_o == (res_o == '0)) && (flag_n_o == res_o[TOP])));

    assert_write_y_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wry_en_i && wr_dst_i == '0) |=> (y_o == $past(op_a_i + op_b_i)));

    assert_bad_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wry_en_i && wr_dst_i != '0) |=> ($stable(y_o) && illegal_o));

    assert_bad_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_src_i != '0) |-> (rd_data_o == '0));

    assert_collide_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && wry_en_i) |=> (collide_o && $stable(res_o)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en_i && !wry_en_i) |=> ($stable(y_o) && $stable(res_o)));

endmodule

bind mulstep_unit mulstep_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en_i (step_en_i),
    .wry_en_i  (wry_en_i),
    .rd_en_i   (rd_en_i),
    .wr_dst_i  (wr_dst_i),
    .rd_src_i  (rd_src_i),
    .op_a_i    (op_a_i),
    .op_b_i    (op_b_i),
    .res_o     (res_o),
    .flag_n_o  (flag_n_o),
    .flag_z_o  (flag_z_o),
    .y_o       (y_o),
    .rd_data_o (rd_data_o),
    .illegal_o (illegal_o),
    .collide_o (collide_o)
);

// File: tb/sim_mulstep_unit.sv
`timescale 1ns/1ps
module sim_mulstep_unit;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         step_en = 1'b0, wry_en = 1'b0, rd_en = 1'b0;
    logic [4:0]   wr_dst = '0, rd_src = '0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         fn = 1'b0, fv = 1'b0;
    logic [W-1:0] res, y, rdd;
    logic         on, oz, ov, oc, ill, col;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mulstep_unit #(.DATA_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .step_en_i(step_en), .wry_en_i(wry_en),
        .rd_en_i(rd_en), .wr_dst_i(wr_dst), .rd_src_i(rd_src),
        .op_a_i(op_a), .op_b_i(op_b), .flag_n_i(fn), .flag_v_i(fv),
        .res_o(res), .flag_n_o(on), .flag_z_o(oz), .flag_v_o(ov), .flag_c_o(oc),
        .y_o(y), .rd_data_o(rdd), .illegal_o(ill), .collide_o(col)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_y(input logic [W-1:0] a, input logic [W-1:0] b, input logic [4:0] dst);
        op_a = a; op_b = b; wr_dst = dst; wry_en = 1'b1;
        cyc();
        wry_en = 1'b0; wr_dst = '0;
    endtask

    task automatic do_step(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic n, input logic v);
        op_a = a; op_b = b; fn = n; fv = v; step_en = 1'b1;
        cyc();
        step_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [W-1:0] held_res;
        logic [W-1:0] held_y;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check({res, y, on, oz, ov, oc, ill, col} == '0, "R1 reset state",
              int'({res, y, on, oz, ov, oc, ill, col}), 0);

        // R6 write-Y plain and wrapping
        wr_y(4'd9, 4'd5, 5'd0);
        check(y == 4'd14, "R6 write-Y sum", int'(y), 14);
        wr_y(4'd12, 4'd7, 5'd0);
        check(y == 4'd3, "R6 write-Y wraps", int'(y), 3);
        check(ill == 1'b0, "R6 legal write not flagged", int'(ill), 0);

        // R7 illegal destination field
        wr_y(4'd1, 4'd1, 5'd7);
        check(y == 4'd3, "R7 bad write keeps Y", int'(y), 3);
        check(ill == 1'b1, "R7 bad write flagged", int'(ill), 1);
        cyc();
        check(ill == 1'b0, "R7 flag is one pulse", int'(ill), 0);

        // R8 read-Y
        wr_y(4'hA, 4'h0, 5'd0);
        rd_en = 1'b1; rd_src = 5'd0; #1;
        check(rdd == 4'hA, "R8 legal read returns Y", int'(rdd), 10);
        rd_src = 5'd3; #1;
        check(rdd == 4'h0, "R8 bad read returns zero", int'(rdd), 0);
        cyc();
        check(ill == 1'b1, "R8 bad read flagged", int'(ill), 1);
        rd_en = 1'b0; rd_src = '0; #1;
        check(rdd == 4'h0, "R8 no read returns zero", int'(rdd), 0);

        // R9 step and write-Y in one cycle: Y=0xA, bit0=0 so step would give {0,a>>1}
        do_step(4'd6, 4'd0, 1'b0, 1'b0);
        held_res = res;
        op_a = 4'd2; op_b = 4'd1; fn = 1'b1; fv = 1'b0;
        step_en = 1'b1; wry_en = 1'b1; wr_dst = '0;
        cyc();
        step_en = 1'b0; wry_en = 1'b0;
        check(y == 4'd3, "R9 write wins", int'(y), 3);
        check(res == held_res, "R9 step discarded", int'(res), int'(held_res));
        check(col == 1'b1, "R9 collision flagged", int'(col), 1);

        // R10 idle hold
        held_y = y; held_res = res;
        op_a = 4'hF; op_b = 4'hF;
        cyc(); cyc();
        check(y == held_y && res == held_res && col == 1'b0, "R10 idle hold",
              int'({y, res}), int'({held_y, held_res}));

        // R2 R3 R4 R5 exhaustive step sweep
        for (int yv = 0; yv < 16; yv++) begin
            for (int nv = 0; nv < 4; nv++) begin
                for (int a = 0; a < 16; a++) begin
                    for (int b = 0; b < 16; b++) begin
                        logic [W-1:0] a4, b4, y4, o1, o2, er, ey;
                        logic [W:0]   s5;
                        logic         en, ez, ev, ec;
                        int           t;
                        a4 = W'(a); b4 = W'(b); y4 = W'(yv);
                        wr_y(y4, 4'd0, 5'd0);
                        do_step(a4, b4, nv[1], nv[0]);
                        o1 = {nv[1] ^ nv[0], a4[W-1:1]};
                        o2 = y4[0] ? b4 : 4'd0;
                        s5 = {1'b0, o1} + {1'b0, o2};
                        er = s5[W-1:0];
                        ec = s5[W];
                        t  = int'($signed(o1)) + int'($signed(o2));
                        ev = (t > 7) || (t < -8);
                        en = er[W-1];
                        ez = (er == 0);
                        ey = {a4[0], y4[W-1:1]};
                        check({res, on, oz, ov, oc, y} == {er, en, ez, ev, ec, ey},
                              "R2 R3 R4 R5 step sweep",
                              int'({res, on, oz, ov, oc, y}), int'({er, en, ez, ev, ec, ey}));
                    end
                end
            end
        end

        // R11 full product: signed multiplicand times unsigned multiplier
        for (int b = 0; b < 16; b++) begin
            for (int m = 0; m < 16; m++) begin
                logic [W-1:0]   p;
                logic           n, v;
                logic [2*W-1:0] got, expv;
                int             e;
                wr_y(W'(m), 4'd0, 5'd0);
                p = '0; n = 1'b0; v = 1'b0;
                for (int k = 0; k < W; k++) begin
                    do_step(p, W'(b), n, v);
                    p = res; n = on; v = ov;
                end
                do_step(p, 4'd0, n, v);
                got  = {res, y};
                e    = (b >= 8 ? b - 16 : b) * m;
                expv = 8'(e);
                check(got == expv, "R11 product", int'(got), int'(expv));
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule